// File: doc/BRIEF.md
# Three-Output Byte Packet Router

The router takes a stream of variable-length byte packets on a single input and delivers each one to one of three output ports. A packet starts with a header byte that holds the payload length and the destination. The payload bytes follow, and a trailing check byte closes the packet. The check byte is the XOR of the header and every payload byte.

The router stores the whole packet in an internal buffer before it forwards anything. This lets it check the packet first. A packet with an unknown destination or a wrong check byte is thrown away and raises a one-cycle flag. A good packet is replayed byte for byte to its destination port.

Flow control works in both directions. Toward the sender, the router raises a suspend signal while the buffer is occupied. Each output port has its own valid output and its own suspend input, driven by the receiver on that port.

Top module: `pkt_router3`

## Requirements
- R1: The header byte carries the payload length in bits [7:2] and the destination code in bits [1:0]. A good packet appears only on the output port whose index equals the destination code (0, 1 or 2).
- R2: While `in_susp` is low and no packet is being collected, a byte with `in_valid` high is taken as a header. After the header, one byte is consumed on every clock: the payload bytes, then the check byte, which is presented with `in_valid` low.
- R3: A good packet leaves its output port unchanged and in order: header, payload, check byte. The other ports keep valid low and data at zero.
- R4: `in_susp` rises on the cycle after a good packet's check byte is accepted. It stays high until the cycle after that packet's check byte has been shown on the output. At all other times it is low.
- R5: An output port drives valid high with the header and payload bytes. It drives valid low with the check byte. The check byte is shown for exactly one cycle and is taken without regard to that port's suspend input. At most one port is valid at a time.
- R6: While the selected port's suspend input is high, that port's data and valid hold steady and the router does not move to the next byte.
- R7: A packet with destination code 3 is consumed in full and dropped. `err_addr` is high for exactly the one cycle after its check byte is accepted, and no output goes valid.
- R8: A packet with a valid destination but a wrong check byte is dropped. `err_parity` is high for exactly the one cycle after its check byte is accepted. A packet with destination code 3 raises only `err_addr`, whatever its check byte.
- R9: During and right after synchronous active-high reset, `in_susp`, every output valid, every output data byte and both error flags are zero.
- R10: Payload lengths from 1 up to the maximum of 63 bytes are carried, so a full packet occupies up to 65 buffer entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all inputs are sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_data | input | 8 | Incoming packet byte |
| in_valid | input | 1 | High with header and payload bytes, low with the check byte |
| in_susp | output | 1 | Back-pressure to the sender; the sender presents a new byte only while it is low |
| out_data | output | 24 | Output bytes, port p in bits [8p+7:8p] |
| out_valid | output | 3 | Per-port valid, high with header and payload bytes |
| out_susp | input | 3 | Per-port suspend from each receiver |
| err_addr | output | 1 | One-cycle pulse when a packet with destination code 3 is dropped |
| err_parity | output | 1 | One-cycle pulse when a packet with a bad check byte is dropped |

## Verification
Directed packets try the smallest and largest lengths on each of the three ports. Routing mistakes show up as bytes on the wrong port, and counting mistakes show up as a cut-off or overlong packet. Packets that fail only the destination test, only the check-byte test, or both, separate the two drop paths and their flag priority. A long run of random packets follows, with random receiver delays, a receiver that never stalls, and a sender that presents the next packet as soon as it is allowed. This run exposes timing faults in the hold behaviour and in the suspend hand-over between packets, which a per-cycle model of the expected outputs catches on the exact cycle.

// File: rtl/pkt_router_pkg.sv
package pkt_router_pkg;

    localparam int BYTE_W      = 8;
    localparam int LEN_W       = 6;
    localparam int ADDR_W      = 2;
    localparam int NUM_OUT     = 3;
    localparam int MAX_PAYLOAD = (1 << LEN_W) - 1;
    localparam int PKT_MAX     = MAX_PAYLOAD + 2;
    localparam int PTR_W       = $clog2(PKT_MAX);
    localparam int REM_W       = LEN_W + 1;

    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [PTR_W-1:0]  ptr_t;

    typedef struct packed {
        logic [LEN_W-1:0]  len;
        logic [ADDR_W-1:0] dest;
    } hdr_t;

    typedef enum logic {
        ING_IDLE,
        ING_BODY
    } ing_state_e;

    typedef struct packed {
        ptr_t              last;
        logic [ADDR_W-1:0] dest;
    } launch_t;

    function automatic hdr_t decode_hdr(input byte_t b);
        return hdr_t'(b);
    endfunction

    function automatic logic dest_ok(input logic [ADDR_W-1:0] d);
        return int'(d) < NUM_OUT;
    endfunction

endpackage

// File: rtl/pr_pktbuf.sv
module pr_pktbuf
    import pkt_router_pkg::*;
(
    input  logic  clk,
    input  logic  wr_en,
    input  ptr_t  wr_addr,
    input  byte_t wr_data,
    input  ptr_t  rd_addr,
    output byte_t rd_data
);

    byte_t mem [PKT_MAX];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end

    assign rd_data = mem[rd_addr];

endmodule

// File: rtl/pr_ingress.sv
module pr_ingress
    import pkt_router_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  byte_t   in_data,
    input  logic    in_valid,
    input  logic    hold,
    output logic    wr_en,
    output ptr_t    wr_addr,
    output byte_t   wr_data,
    output logic    launch,
    output launch_t launch_info,
    output logic    err_addr,
    output logic    err_parity
);

    localparam logic [REM_W-1:0] REM_ONE = 1;
    localparam ptr_t             PTR_ONE = 1;

    ing_state_e        st;
    logic [REM_W-1:0]  rem;
    byte_t             acc;
    logic [ADDR_W-1:0] dest_q;
    ptr_t              ptr;

    logic take, trailer, dest_bad, sum_bad;
    hdr_t hdr_in;

    assign hdr_in   = decode_hdr(in_data);
    assign take     = !hold && ((st == ING_BODY) || in_valid);
    assign trailer  = (st == ING_BODY) && (rem == REM_ONE);
    assign dest_bad = !dest_ok(dest_q);
    assign sum_bad  = (acc != in_data);

    assign wr_en   = take;
    assign wr_addr = (st == ING_IDLE) ? '0 : ptr;
    assign wr_data = in_data;

    assign launch           = take && trailer && !dest_bad && !sum_bad;
    assign launch_info.last = ptr;
    assign launch_info.dest = dest_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= ING_IDLE;
            rem        <= '0;
            acc        <= '0;
            dest_q     <= '0;
            ptr        <= '0;
            err_addr   <= 1'b0;
            err_parity <= 1'b0;
        end else begin
            err_addr   <= 1'b0;
            err_parity <= 1'b0;
            if (take) begin
                unique case (st)
                    ING_IDLE: begin
                        dest_q <= hdr_in.dest;
                        acc    <= in_data;
                        rem    <= {1'b0, hdr_in.len} + REM_ONE;
                        ptr    <= PTR_ONE;
                        st     <= ING_BODY;
                    end
                    ING_BODY: begin
                        ptr <= ptr + PTR_ONE;
                        if (trailer) begin
                            st         <= ING_IDLE;
                            err_addr   <= dest_bad;
                            err_parity <= !dest_bad && sum_bad;
                        end else begin
                            acc <= acc ^ in_data;
                            rem <= rem - REM_ONE;
                        end
                    end
                    default: st <= ING_IDLE;
                endcase
            end
        end
    end

endmodule

// File: rtl/pr_egress.sv
module pr_egress
    import pkt_router_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      launch,
    input  launch_t                   launch_info,
    output ptr_t                      rd_addr,
    input  byte_t                     rd_data,
    input  logic [NUM_OUT-1:0]        out_susp,
    output logic [NUM_OUT-1:0]        out_valid,
    output logic [NUM_OUT*BYTE_W-1:0] out_data,
    output logic                      busy
);

    localparam ptr_t PTR_ONE = 1;

    ptr_t              idx;
    ptr_t              last;
    logic [ADDR_W-1:0] dest;
    logic [NUM_OUT-1:0] held;
    logic              at_trailer;

    assign at_trailer = (idx == last);
    assign rd_addr    = idx;

    for (genvar p = 0; p < NUM_OUT; p++) begin : g_port
        logic mine;
        assign mine         = busy && (dest == ADDR_W'(p));
        assign out_valid[p] = mine && !at_trailer;
        assign out_data[p*BYTE_W +: BYTE_W] = mine ? rd_data : '0;
        assign held[p]      = mine && out_susp[p];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            idx  <= '0;
            last <= '0;
            dest <= '0;
        end else if (!busy) begin
            if (launch) begin
                busy <= 1'b1;
                idx  <= '0;
                last <= launch_info.last;
                dest <= launch_info.dest;
            end
        end else if (at_trailer) begin
            busy <= 1'b0;
        end else if (!(|held)) begin
            idx <= idx + PTR_ONE;
        end
    end

endmodule

// File: rtl/pkt_router3.sv
module pkt_router3
    import pkt_router_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst,
    input  logic [BYTE_W-1:0]         in_data,
    input  logic                      in_valid,
    output logic                      in_susp,
    output logic [NUM_OUT*BYTE_W-1:0] out_data,
    output logic [NUM_OUT-1:0]        out_valid,
    input  logic [NUM_OUT-1:0]        out_susp,
    output logic                      err_addr,
    output logic                      err_parity
);

    logic    wr_en;
    ptr_t    wr_addr;
    byte_t   wr_data;
    ptr_t    rd_addr;
    byte_t   rd_data;
    logic    launch;
    launch_t launch_info;
    logic    eg_busy;

    assign in_susp = eg_busy;

    pr_ingress u_ing (
        .clk         (clk),
        .rst         (rst),
        .in_data     (in_data),
        .in_valid    (in_valid),
        .hold        (eg_busy),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .launch      (launch),
        .launch_info (launch_info),
        .err_addr    (err_addr),
        .err_parity  (err_parity)
    );

    pr_pktbuf u_buf (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    pr_egress u_egr (
        .clk         (clk),
        .rst         (rst),
        .launch      (launch),
        .launch_info (launch_info),
        .rd_addr     (rd_addr),
        .rd_data     (rd_data),
        .out_susp    (out_susp),
        .out_valid   (out_valid),
        .out_data    (out_data),
        .busy        (eg_busy)
    );

endmodule

// File: rtl/pr_router_chk.sv
module pr_router_chk
    import pkt_router_pkg::*;
(
    input logic                      clk,
    input logic                      rst,
    input logic                      in_susp,
    input logic [NUM_OUT*BYTE_W-1:0] out_data,
    input logic [NUM_OUT-1:0]        out_valid,
    input logic [NUM_OUT-1:0]        out_susp,
    input logic                      err_addr,
    input logic                      err_parity
);

    // R5
    single_port_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(out_valid));

    // R4
    susp_while_out_chk: assert property (@(posedge clk) disable iff (rst)
        (|out_valid) |-> in_susp);

    // R7
    addr_err_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        err_addr |=> !err_addr);

    // R7
    addr_drop_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        err_addr |-> (!in_susp && (out_valid == '0)));

    // R8
    par_err_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        err_parity |=> !err_parity);

    // R8
    err_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        err_addr |-> !err_parity);

    for (genvar p = 0; p < NUM_OUT; p++) begin : g_chk
        // R6
        hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
            (out_valid[p] && out_susp[p]) |=>
                (out_valid[p] && $stable(out_data[p*BYTE_W +: BYTE_W])));

        // R5
        trailer_one_cycle_chk: assert property (@(posedge clk) disable iff (rst)
            $fell(out_valid[p]) |=> (!in_susp && !out_valid[p]));
    end

endmodule

bind pkt_router3 pr_router_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .in_susp    (in_susp),
    .out_data   (out_data),
    .out_valid  (out_valid),
    .out_susp   (out_susp),
    .err_addr   (err_addr),
    .err_parity (err_parity)
);

// File: tb/sim_pkt_router3.sv
module sim_pkt_router3;

    logic        clk = 1'b0;
    logic        rst;
    logic [7:0]  in_data;
    logic        in_valid;
    logic        in_susp;
    logic [23:0] out_data;
    logic [2:0]  out_valid;
    logic [2:0]  out_susp;
    logic        err_addr;
    logic        err_parity;

    always #4 clk = ~clk;

    pkt_router3 u0 (
        .clk        (clk),
        .rst        (rst),
        .in_data    (in_data),
        .in_valid   (in_valid),
        .in_susp    (in_susp),
        .out_data   (out_data),
        .out_valid  (out_valid),
        .out_susp   (out_susp),
        .err_addr   (err_addr),
        .err_parity (err_parity)
    );

    int n_chk = 0;
    int n_err = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int         m_mode;   // 0 idle, 1 collecting, 2 sending
    int         m_rem, m_idx, m_port;
    logic [7:0] m_acc;
    logic [7:0] m_q[$];
    bit         m_ea, m_ep;

    always @(posedge clk) begin
        if (rst) begin
            m_mode = 0; m_idx = 0; m_port = 0; m_ea = 0; m_ep = 0;
            m_q.delete();
        end else begin
            m_ea = 0; m_ep = 0;
            case (m_mode)
                0: if (in_valid) begin
                    m_q.delete();
                    m_q.push_back(in_data);
                    m_rem  = int'(in_data[7:2]) + 1;
                    m_acc  = in_data;
                    m_mode = 1;
                end
                1: begin
                    m_q.push_back(in_data);
                    m_rem--;
                    if (m_rem == 0) begin
                        if (m_q[0][1:0] == 2'd3) begin
                            m_ea = 1; m_mode = 0;
                        end else if (m_acc != in_data) begin
                            m_ep = 1; m_mode = 0;
                        end else begin
                            m_mode = 2; m_idx = 0; m_port = int'(m_q[0][1:0]);
                        end
                    end else begin
                        m_acc ^= in_data;
                    end
                end
                default: begin
                    if (m_idx == m_q.size() - 1) m_mode = 0;
                    else if (!out_susp[m_port]) m_idx++;
                end
            endcase
        end
    end

    int n_seen_ea = 0, n_seen_ep = 0;

    always @(negedge clk) begin
        if (!rst) begin
            logic        e_susp;
            logic [2:0]  e_valid;
            logic [23:0] e_data;
            e_susp  = (m_mode == 2);
            e_valid = '0;
            e_data  = '0;
            if (m_mode == 2) begin
                e_valid[m_port] = (m_idx < m_q.size() - 1);
                e_data[m_port*8 +: 8] = m_q[m_idx];
            end
            check(in_susp === e_susp, "R2 R4", "in_susp", 32'(in_susp), 32'(e_susp));
            check(out_valid === e_valid, "R5", "out_valid", 32'(out_valid), 32'(e_valid));
            check(out_data === e_data, "R3/R6", "out_data", 32'(out_data), 32'(e_data));
            check(err_addr === m_ea, "R7", "err_addr", 32'(err_addr), 32'(m_ea));
            check(err_parity === m_ep, "R8", "err_parity", 32'(err_parity), 32'(m_ep));
            if (err_addr === 1'b1) n_seen_ea++;
            if (err_parity === 1'b1) n_seen_ep++;
        end
    end

    // ---------------- receivers and scoreboard ----------------
    logic [7:0] sb [0:2][$];
    int rx_dly [3];
    int rx_len [3];
    int rx_max_dly = 4;
    int n_max_seen = 0, n_min_seen = 0;

    task automatic rx_byte(input int p, input logic [7:0] b);
        if (sb[p].size() == 0) begin
            check(1'b0, "R3", "unexpected byte", 32'(b), 32'hFFFF);
        end else begin
            logic [7:0] e;
            e = sb[p].pop_front();
            check(b === e, "R3", "delivered byte", 32'(b), 32'(e));
        end
        if (rx_len[p] == 0) begin
            check(int'(b[1:0]) == p, "R1", "port vs dest", 32'(p), 32'(b[1:0]));
        end
        rx_len[p]++;
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            for (int p = 0; p < 3; p++) begin
                if (out_valid[p]) begin
                    if (out_susp[p]) begin
                        if (rx_dly[p] == 0) out_susp[p] = 1'b0;
                        else rx_dly[p]--;
                    end
                    if (!out_susp[p]) rx_byte(p, out_data[p*8 +: 8]);
                end else if (!out_susp[p]) begin
                    rx_byte(p, out_data[p*8 +: 8]);
                    if (rx_len[p] == 65) n_max_seen++;
                    if (rx_len[p] == 3)  n_min_seen++;
                    rx_len[p]   = 0;
                    out_susp[p] = 1'b1;
                    rx_dly[p]   = int'($urandom_range(0, rx_max_dly));
                end
            end
        end
    end

    // ---------------- sender ----------------
    int n_exp_ea = 0, n_exp_ep = 0;

    task automatic send_pkt(input int len, input int dest, input bit bad);
        logic [7:0] b[$];
        logic [7:0] par;
        b.push_back({6'(len), 2'(dest)});
        par = b[0];
        for (int i = 0; i < len; i++) begin
            logic [7:0] d;
            d = 8'($urandom);
            b.push_back(d);
            par ^= d;
        end
        if (bad) par ^= 8'h01;
        b.push_back(par);
        if (dest == 3) n_exp_ea++;
        else if (bad) n_exp_ep++;
        else foreach (b[k]) sb[dest].push_back(b[k]);
        for (int i = 0; i < b.size(); i++) begin
            @(negedge clk);
            while (in_susp) @(negedge clk);
            in_data  = b[i];
            in_valid = (i < b.size() - 1);
        end
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    // ---------------- main sequence ----------------
    initial begin
        rst      = 1'b1;
        in_data  = '0;
        in_valid = 1'b0;
        out_susp = 3'b111;
        for (int p = 0; p < 3; p++) begin
            rx_dly[p] = 2;
            rx_len[p] = 0;
        end
        repeat (3) @(negedge clk);
        // R9 reset state
        check(in_susp === 1'b0, "R9", "in_susp", 32'(in_susp), 0);
        check(out_valid === 3'b0, "R9", "out_valid", 32'(out_valid), 0);
        check(out_data === 24'b0, "R9", "out_data", out_data, 0);
        check(err_addr === 1'b0 && err_parity === 1'b0, "R9", "errors",
              32'({err_addr, err_parity}), 0);
        rst = 1'b0;

        // R10 smallest and largest lengths on every port
        for (int p = 0; p < 3; p++) begin
            send_pkt(1, p, 1'b0);
            send_pkt(63, p, 1'b0);
            send_pkt(7 + p * 11, p, 1'b0);
        end
        // R7 and R8 drops, including the priority case
        send_pkt(4, 3, 1'b0);
        send_pkt(5, 1, 1'b1);
        send_pkt(6, 3, 1'b1);
        send_pkt(2, 2, 1'b0);

        // receiver never stalls
        rx_max_dly = 0;
        for (int n = 0; n < 15; n++) begin
            send_pkt(int'($urandom_range(1, 63)), int'($urandom_range(0, 2)), 1'b0);
        end
        // random mix with random receiver delays
        rx_max_dly = 6;
        for (int n = 0; n < 40; n++) begin
            int d;
            d = int'($urandom_range(0, 9));
            send_pkt(int'($urandom_range(1, 63)), (d == 9) ? 3 : d % 3, d == 8);
        end

        @(negedge clk);
        in_valid = 1'b0;
        for (int w = 0; w < 2000; w++) begin
            if (m_mode == 0 && sb[0].size() == 0 && sb[1].size() == 0 && sb[2].size() == 0)
                break;
            @(negedge clk);
        end
        repeat (4) @(negedge clk);
        for (int p = 0; p < 3; p++) begin
            check(sb[p].size() == 0, "R3", "bytes left undelivered", 32'(sb[p].size()), 0);
        end
        check(n_seen_ea == n_exp_ea, "R7", "address drops", 32'(n_seen_ea), 32'(n_exp_ea));
        check(n_seen_ep == n_exp_ep, "R8", "check-byte drops", 32'(n_seen_ep), 32'(n_exp_ep));
        check(n_max_seen >= 3, "R10", "max-length packets delivered", 32'(n_max_seen), 3);
        check(n_min_seen >= 3, "R10", "min-length packets delivered", 32'(n_min_seen), 3);
        $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule